// File: doc/BRIEF.md
# Cache Miss Slot Invalidation Tracker

This block sits next to the miss handling controller of a set-associative cache. It keeps track of the one slot that is reserved for an outstanding line refill. When the refill ends, it produces the directory write for that slot. A coherence invalidation can arrive for the same line while the refill is still in flight. When that happens, the tracker records the race, and at directory-update time it writes the slot as ZOMBI instead of VALID. It then raises a cleanup request so that the home node learns the copy was dropped.

The controller announces each new miss with its physical address, way and set. For a page-table-entry refill, the address comes from the table-walk address instead. When the chosen way still holds a valid victim line, the tracker raises a cleanup for that victim. It then keeps a flag up until the cleanup is acknowledged. The controller also presents each coherence invalidation together with the state it interrupted. The tracker answers at once whether the invalidation hits the pending miss. A single cleanup register feeds the cleanup channel. It holds one request at a time.

Top module: `miss_slot_tracker`

## Requirements
- R1: After reset, no cleanup request is raised (`cln_req_o`=0), no acknowledge is awaited (`clack_wait_o`=0), and the miss-invalidated flag is clear, so the first directory update writes VALID.
- R2: An accepted miss (`miss_ack_o`=1) saves the address, way and set used by later directory writes. The saved address is `walk_paddr_i` when `miss_pte_i`=1 and `miss_paddr_i` otherwise.
- R3: A directory step (`dir_step_i`) with the flag clear drives `dir_we_o`=1 in the same cycle. It carries the saved address, way and set, with `dir_state_o`=1 (VALID). Slot states use 2 bits: EMPTY=0, VALID=1, ZOMBI=2.
- R4: An invalidation hits (`inval_hit_o`=1, same cycle) only when two conditions hold. First, `inval_state_i` is 1 (waiting for miss data) or 2 (directory update after miss). Second, both addresses are equal after masking with ~(WORDS*4-1). A hit sets the miss-invalidated flag.
- R5: An invalidation in any other state (`inval_state_i`=0), or one on a different line, does not hit. The next directory write is then VALID.
- R6: A directory step with the flag set and no pending cleanup writes ZOMBI (2). On the next cycle it raises a cleanup with line = saved address >> log2(WORDS*4) and the saved way. It also clears the flag.
- R7: A directory step with the flag set while a cleanup is pending produces no directory write and changes nothing.
- R8: An accepted miss with `victim_vld_i`=1 raises a cleanup for `victim_line_i` and `miss_way_i` and sets `clack_wait_o` on the next cycle. `clack_i` clears `clack_wait_o`.
- R9: A miss with a victim is refused (`miss_ack_o`=0) while a cleanup is pending, and the refused miss saves nothing.
- R10: A raised cleanup holds its request, line and way until `cln_ack_i` or `inval_done_i` removes it.
- R11: `inval_done_i`, which marks the return of coherence handling to the saved state, withdraws a pending cleanup request by the next cycle.
- R12: `dir_step_i` is ignored while `inval_vld_i` or `miss_start_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_start_i | input | 1 | New miss announced |
| miss_pte_i | input | 1 | Miss is a page-table-entry refill |
| miss_paddr_i | input | PADDR_W | Miss physical address |
| walk_paddr_i | input | PADDR_W | Table-walk physical address |
| miss_way_i | input | log2(WAYS) | Way chosen for the refill |
| miss_set_i | input | log2(SETS) | Set of the refill |
| victim_vld_i | input | 1 | Chosen way holds a valid line |
| victim_line_i | input | PADDR_W-log2(WORDS*4) | Victim line index |
| miss_ack_o | output | 1 | Miss accepted this cycle |
| inval_vld_i | input | 1 | Coherence invalidation presented |
| inval_paddr_i | input | PADDR_W | Invalidation address |
| inval_state_i | input | 2 | Interrupted controller state: 0 other, 1 wait data, 2 dir update |
| inval_done_i | input | 1 | Coherence handling returns to saved state |
| inval_hit_o | output | 1 | Invalidation hits the pending miss |
| dir_step_i | input | 1 | Controller in directory-update step |
| dir_we_o | output | 1 | Directory write |
| dir_paddr_o | output | PADDR_W | Directory write address |
| dir_way_o | output | log2(WAYS) | Directory write way |
| dir_set_o | output | log2(SETS) | Directory write set |
| dir_state_o | output | 2 | New slot state |
| cln_req_o | output | 1 | Cleanup request |
| cln_line_o | output | PADDR_W-log2(WORDS*4) | Cleanup line index |
| cln_way_o | output | log2(WAYS) | Cleanup way |
| cln_ack_i | input | 1 | Cleanup channel accept |
| clack_wait_o | output | 1 | Victim cleanup acknowledge awaited |
| clack_i | input | 1 | Cleanup acknowledge received |

## Verification
The bench targets the race itself. It sends invalidations whose offset differs from the miss address only inside the line, and others one line away. A design with a wrong mask would either miss the hit and write VALID, or hit the neighbouring line and write ZOMBI. It also sends an invalidation with a matching address while the controller is in an unrelated state; a design that ignores the state would then turn a good slot into ZOMBI. It steps the directory update while a victim cleanup is still pending. A design that does not wait would overwrite the held cleanup line, and the channel would see a corrupted request. Finally, it checks that a PTE refill is written at the walk address, and that withdrawal by `inval_done_i` drops the request.

// File: rtl/mst_pkg.sv
package mst_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_VALID = 2'd1,
    SLOT_ZOMBI = 2'd2
  } slot_state_e;

  typedef enum logic [1:0] {
    CTL_OTHER     = 2'd0,
    CTL_MISS_WAIT = 2'd1,
    CTL_MISS_DIR  = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/mst_line_match.sv
module mst_line_match #(
  parameter int PADDR_W = 32,
  parameter int OFS_W   = 5
) (
  input  logic [PADDR_W-1:0] a_i,
  input  logic [PADDR_W-1:0] b_i,
  output logic               same_o
);
  localparam logic [PADDR_W-1:0] LINE_MASK = {{(PADDR_W-OFS_W){1'b1}}, {OFS_W{1'b0}}};

  always_comb begin
    same_o = ((a_i & LINE_MASK) == (b_i & LINE_MASK));
  end
endmodule

// File: rtl/mst_cleanup_reg.sv
module mst_cleanup_reg #(
  parameter int LINE_W = 27,
  parameter int WAY_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raise_i,
  input  logic [LINE_W-1:0] raise_line_i,
  input  logic [WAY_W-1:0]  raise_way_i,
  input  logic              accept_i,
  input  logic              drop_i,
  output logic              req_o,
  output logic [LINE_W-1:0] line_o,
  output logic [WAY_W-1:0]  way_o
);
  logic req_d;

  always_comb begin
    req_d = req_o;
    if (raise_i)                   req_d = 1'b1;
    else if (accept_i || drop_i)   req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_o <= 1'b0;
    else        req_o <= req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_o <= '0;
      way_o  <= '0;
    end else if (raise_i) begin
      line_o <= raise_line_i;
      way_o  <= raise_way_i;
    end
  end
endmodule

// File: rtl/miss_slot_tracker.sv
module miss_slot_tracker
  import mst_pkg::*;
#(
  parameter int PADDR_W = 32,
  parameter int WAYS    = 4,
  parameter int SETS    = 64,
  parameter int WORDS   = 8,
  localparam int OFS_W  = $clog2(WORDS*4),
  localparam int LINE_W = PADDR_W - OFS_W,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int SET_W  = $clog2(SETS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_start_i,
  input  logic               miss_pte_i,
  input  logic [PADDR_W-1:0] miss_paddr_i,
  input  logic [PADDR_W-1:0] walk_paddr_i,
  input  logic [WAY_W-1:0]   miss_way_i,
  input  logic [SET_W-1:0]   miss_set_i,
  input  logic               victim_vld_i,
  input  logic [LINE_W-1:0]  victim_line_i,
  output logic               miss_ack_o,
  input  logic               inval_vld_i,
  input  logic [PADDR_W-1:0] inval_paddr_i,
  input  logic [1:0]         inval_state_i,
  input  logic               inval_done_i,
  output logic               inval_hit_o,
  input  logic               dir_step_i,
  output logic               dir_we_o,
  output logic [PADDR_W-1:0] dir_paddr_o,
  output logic [WAY_W-1:0]   dir_way_o,
  output logic [SET_W-1:0]   dir_set_o,
  output logic [1:0]         dir_state_o,
  output logic               cln_req_o,
  output logic [LINE_W-1:0]  cln_line_o,
  output logic [WAY_W-1:0]   cln_way_o,
  input  logic               cln_ack_i,
  output logic               clack_wait_o,
  input  logic               clack_i
);
  logic [PADDR_W-1:0] save_paddr_q, save_paddr_d;
  logic [WAY_W-1:0]   save_way_q;
  logic [SET_W-1:0]   save_set_q;
  logic               zombi_q, zombi_d;
  logic               clack_d;
  logic               line_same, ctl_in_window;
  logic               dir_go, vict_raise, zomb_raise, cln_raise;
  logic [LINE_W-1:0]  raise_line;

  mst_line_match #(.PADDR_W(PADDR_W), .OFS_W(OFS_W)) u_match (
    .a_i    (save_paddr_q),
    .b_i    (inval_paddr_i),
    .same_o (line_same)
  );

  always_comb begin
    miss_ack_o    = miss_start_i & ~(victim_vld_i & cln_req_o);
    save_paddr_d  = miss_pte_i ? walk_paddr_i : miss_paddr_i;
    ctl_in_window = (inval_state_i == CTL_MISS_WAIT) || (inval_state_i == CTL_MISS_DIR);
    inval_hit_o   = inval_vld_i & ctl_in_window & line_same;
    dir_go        = dir_step_i & ~inval_vld_i & ~miss_start_i;
    dir_we_o      = dir_go & ~(zombi_q & cln_req_o);
    dir_state_o   = zombi_q ? SLOT_ZOMBI : SLOT_VALID;
    dir_paddr_o   = save_paddr_q;
    dir_way_o     = save_way_q;
    dir_set_o     = save_set_q;
    vict_raise    = miss_ack_o & victim_vld_i;
    zomb_raise    = dir_we_o & zombi_q;
    cln_raise     = vict_raise | zomb_raise;
    raise_line    = vict_raise ? victim_line_i : save_paddr_q[PADDR_W-1:OFS_W];
  end

  always_comb begin
    zombi_d = zombi_q;
    if (miss_ack_o)       zombi_d = 1'b0;
    else if (inval_hit_o) zombi_d = 1'b1;
    else if (zomb_raise)  zombi_d = 1'b0;
  end

  always_comb begin
    clack_d = clack_wait_o;
    if (vict_raise)   clack_d = 1'b1;
    else if (clack_i) clack_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zombi_q      <= 1'b0;
      clack_wait_o <= 1'b0;
    end else begin
      zombi_q      <= zombi_d;
      clack_wait_o <= clack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      save_paddr_q <= '0;
      save_way_q   <= '0;
      save_set_q   <= '0;
    end else if (miss_ack_o) begin
      save_paddr_q <= save_paddr_d;
      save_way_q   <= miss_way_i;
      save_set_q   <= miss_set_i;
    end
  end

  mst_cleanup_reg #(.LINE_W(LINE_W), .WAY_W(WAY_W)) u_cln (
    .clk          (clk),
    .rst_n        (rst_n),
    .raise_i      (cln_raise),
    .raise_line_i (raise_line),
    .raise_way_i  (vict_raise ? miss_way_i : save_way_q),
    .accept_i     (cln_ack_i),
    .drop_i       (inval_done_i),
    .req_o        (cln_req_o),
    .line_o       (cln_line_o),
    .way_o        (cln_way_o)
  );
endmodule

// File: rtl/mst_checker.sv
module mst_checker #(
  parameter int PADDR_W = 32,
  parameter int WAYS    = 4,
  parameter int SETS    = 64,
  parameter int WORDS   = 8,
  localparam int LINE_W = PADDR_W - $clog2(WORDS*4),
  localparam int WAY_W  = $clog2(WAYS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_start_i,
  input logic              victim_vld_i,
  input logic              miss_ack_o,
  input logic              inval_vld_i,
  input logic              inval_done_i,
  input logic              dir_we_o,
  input logic [1:0]        dir_state_o,
  input logic              cln_req_o,
  input logic [LINE_W-1:0] cln_line_o,
  input logic [WAY_W-1:0]  cln_way_o,
  input logic              cln_ack_i,
  input logic              clack_wait_o
);
  // R10
  cln_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cln_req_o && !cln_ack_i && !inval_done_i) |=>
      (cln_req_o && $stable(cln_line_o) && $stable(cln_way_o)));

  // R7
  zombi_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_we_o && dir_state_o == 2'd2) |-> !cln_req_o);

  // R6
  zombi_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_we_o && dir_state_o == 2'd2) |=> cln_req_o);

  // R3
  dir_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_we_o |-> (dir_state_o == 2'd1 || dir_state_o == 2'd2));

  // R12
  dir_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_vld_i || miss_start_i) |-> !dir_we_o);

  // R8
  victim_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_ack_o && victim_vld_i) |=> (cln_req_o && clack_wait_o));

  // R9
  victim_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_start_i && victim_vld_i && cln_req_o) |-> !miss_ack_o);

  // R11
  withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_done_i && cln_req_o) |=> !cln_req_o);
endmodule

bind miss_slot_tracker mst_checker #(
  .PADDR_W(PADDR_W), .WAYS(WAYS), .SETS(SETS), .WORDS(WORDS)
) u_chk (.*);

// File: tb/miss_slot_tracker_tb.sv
module miss_slot_tracker_tb;
  localparam int PW = 32, WW = 2, SW = 6, LW = 27;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic miss_start_i = 0, miss_pte_i = 0, victim_vld_i = 0;
  logic [PW-1:0] miss_paddr_i = '0, walk_paddr_i = '0, inval_paddr_i = '0;
  logic [WW-1:0] miss_way_i = '0;
  logic [SW-1:0] miss_set_i = '0;
  logic [LW-1:0] victim_line_i = '0;
  logic inval_vld_i = 0, inval_done_i = 0, dir_step_i = 0, cln_ack_i = 0, clack_i = 0;
  logic [1:0] inval_state_i = 2'd0;
  logic miss_ack_o, inval_hit_o, dir_we_o, cln_req_o, clack_wait_o;
  logic [PW-1:0] dir_paddr_o;
  logic [WW-1:0] dir_way_o, cln_way_o;
  logic [SW-1:0] dir_set_o;
  logic [1:0] dir_state_o;
  logic [LW-1:0] cln_line_o;

  miss_slot_tracker u_dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  logic [PW+WW+SW+1:0] exp_dir[$];
  logic [LW+WW-1:0]    exp_cln[$];

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when the design produces a result
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (dir_we_o) begin
        if (exp_dir.size() == 0) chk(0, "R3 unexpected dir write", {dir_paddr_o, dir_state_o}, 0);
        else begin
          logic [PW+WW+SW+1:0] e;
          e = exp_dir.pop_front();
          chk({dir_paddr_o, dir_way_o, dir_set_o, dir_state_o} == e, "R3/R6 dir write",
              {dir_paddr_o, dir_way_o, dir_set_o, dir_state_o}, e);
        end
      end
      if (cln_req_o && cln_ack_i) begin
        if (exp_cln.size() == 0) chk(0, "R6/R8 unexpected cleanup", {cln_line_o, cln_way_o}, 0);
        else begin
          logic [LW+WW-1:0] c;
          c = exp_cln.pop_front();
          chk({cln_line_o, cln_way_o} == c, "R6/R8 cleanup", {cln_line_o, cln_way_o}, c);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_miss(logic [PW-1:0] pa, bit pte, logic [PW-1:0] wa, logic [WW-1:0] w,
                         logic [SW-1:0] s, bit vv, logic [LW-1:0] vl, bit exp_ack);
    miss_start_i = 1; miss_pte_i = pte; miss_paddr_i = pa; walk_paddr_i = wa;
    miss_way_i = w; miss_set_i = s; victim_vld_i = vv; victim_line_i = vl;
    #2 chk(miss_ack_o == exp_ack, "R9 miss acceptance", miss_ack_o, exp_ack);
    if (exp_ack && vv) exp_cln.push_back({vl, w});
    step();
    miss_start_i = 0; victim_vld_i = 0; miss_pte_i = 0;
  endtask

  task automatic dir_cmd(bit exp_we, logic [PW-1:0] pa, logic [WW-1:0] w, logic [SW-1:0] s,
                         logic [1:0] st);
    if (exp_we) exp_dir.push_back({pa, w, s, st});
    if (exp_we && st == 2'd2) exp_cln.push_back({pa[PW-1:5], w});
    dir_step_i = 1;
    #2 chk(dir_we_o == exp_we, "R7/R12 dir write enable", dir_we_o, exp_we);
    step();
    dir_step_i = 0;
  endtask

  task automatic inval(logic [PW-1:0] pa, logic [1:0] st, bit exp_hit);
    inval_vld_i = 1; inval_paddr_i = pa; inval_state_i = st;
    #2 chk(inval_hit_o == exp_hit, "R4/R5 invalidation hit", inval_hit_o, exp_hit);
    step();
    inval_vld_i = 0; inval_state_i = 2'd0;
  endtask

  task automatic accept();
    cln_ack_i = 1; step(); cln_ack_i = 0;
  endtask

  initial begin
    repeat (3) step();
    // R1 reset state
    chk(cln_req_o == 0, "R1 cleanup idle", cln_req_o, 0);
    chk(clack_wait_o == 0, "R1 no ack awaited", clack_wait_o, 0);
    rst_n = 1; step();
    dir_cmd(1, 32'h0, 2'd0, 6'd0, 2'd1); // R1 flag clear -> VALID
    // R3 plain miss
    do_miss(32'h1000_0040, 0, 32'h0, 2'd1, 6'd2, 0, '0, 1);
    dir_cmd(1, 32'h1000_0040, 2'd1, 6'd2, 2'd1);
    // R2 PTE miss uses walk address
    do_miss(32'h5555_0000, 1, 32'h2000_0100, 2'd3, 6'd5, 0, '0, 1);
    dir_cmd(1, 32'h2000_0100, 2'd3, 6'd5, 2'd1);
    // R4 hit inside line during wait, R6 zombi + cleanup
    do_miss(32'h3000_0080, 0, 32'h0, 2'd2, 6'd4, 0, '0, 1);
    inval(32'h3000_009C, 2'd1, 1);
    dir_cmd(1, 32'h3000_0080, 2'd2, 6'd4, 2'd2);
    chk(cln_req_o == 1, "R6 cleanup raised", cln_req_o, 1);
    accept();
    dir_cmd(1, 32'h3000_0080, 2'd2, 6'd4, 2'd1); // R6 flag cleared
    // R5 other line / other state
    inval(32'h3000_00A0, 2'd1, 0);
    inval(32'h3000_0084, 2'd0, 0);
    dir_cmd(1, 32'h3000_0080, 2'd2, 6'd4, 2'd1);
    // R8 victim cleanup, R4 hit in dir state, R7 wait, R9 refuse, R10 hold
    do_miss(32'h4000_0100, 0, 32'h0, 2'd0, 6'd7, 1, 27'h0ABCDE, 1);
    chk(clack_wait_o == 1, "R8 ack awaited", clack_wait_o, 1);
    inval(32'h4000_0110, 2'd2, 1);
    dir_cmd(0, 32'h0, 2'd0, 6'd0, 2'd0);
    do_miss(32'h6000_0000, 0, 32'h0, 2'd1, 6'd9, 1, 27'h0777, 0);
    step(); step();
    chk(cln_req_o == 1 && cln_line_o == 27'h0ABCDE, "R10 cleanup held", cln_line_o, 27'h0ABCDE);
    accept();
    dir_cmd(1, 32'h4000_0100, 2'd0, 6'd7, 2'd2);
    accept();
    clack_i = 1; step(); clack_i = 0;
    chk(clack_wait_o == 0, "R8 ack clears wait", clack_wait_o, 0);
    // R11 withdrawal
    do_miss(32'h7000_0020, 0, 32'h0, 2'd1, 6'd3, 1, 27'h0123, 1);
    void'(exp_cln.pop_back());
    inval_done_i = 1; step(); inval_done_i = 0;
    chk(cln_req_o == 0, "R11 cleanup withdrawn", cln_req_o, 0);
    dir_cmd(1, 32'h7000_0020, 2'd1, 6'd3, 2'd1);
    // R12 dir step blocked by a concurrent invalidation
    inval_vld_i = 1; inval_paddr_i = 32'h9000_0000; inval_state_i = 2'd0;
    dir_cmd(0, 32'h0, 2'd0, 6'd0, 2'd0);
    inval_vld_i = 0;
    step(); step();
    chk(exp_dir.size() == 0 && exp_cln.size() == 0, "R3 scoreboard drained",
        exp_dir.size() + exp_cln.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule